// File: doc/BRIEF.md
# Texel offset generator for linear and interleaved surfaces

This block converts a stream of texel coordinates (x, y, z) into byte offsets inside a surface. A surface is described by static configuration inputs: width, height, depth, row pitch in bytes and bytes per texel. A nonzero pitch selects plain row-major addressing. A zero pitch selects an interleaved (Morton-order) layout. That layout is two-dimensional when the depth is one or less and three-dimensional otherwise.

Coordinates enter through a valid/ready handshake and offsets leave through another, one per clock at full rate and always in input order. The block has two register stages. The first computes the texel index or the linear byte address. The second scales the index by the texel size. Interleaved layouts expect power-of-two dimensions no larger than 2^COORD_W. Coordinates are not clipped, so the caller must keep them in range. The configuration must stay constant while coordinates are in flight.

Top module: `swz_addr_gen`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid is 0 and in_ready is 1.
- R2: With cfg_pitch nonzero, the offset is y*cfg_pitch + x*cfg_bpp and z is ignored.
- R3: With cfg_pitch zero, a cfg_depth of 0 or 1 selects the 2D interleave (z ignored). A larger cfg_depth selects the 3D interleave.
- R4: 2D interleave with square size 2^k: bit i of x goes to index bit 2i and bit i of y goes to index bit 2i+1, for i < k.
- R5: 2D interleave with a non-square size: k = log2(min(width, height)). The index is the in-tile interleave of the low k bits, plus ((y>>k)*(width>>k) + (x>>k)) shifted left by 2k.
- R6: 3D interleave: index bits are filled in rounds. Each round takes the next x bit, then the next y bit, then the next z bit. An axis is skipped once it has given log2 of its size bits.
- R7: In both interleaved modes the byte offset equals the texel index times cfg_bpp.
- R8: A coordinate accepted at a rising edge (in_valid and in_ready high) produces out_valid after the next rising edge when out_ready is held high. Offsets come out in acceptance order, one per cycle.
- R9: While out_valid is high and out_ready is low, out_valid and out_offset hold and in_ready is low.
- R10: Coordinates beyond the surface size are not clipped. In linear mode, an x past the row width still gives y*pitch + x*bpp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_width | input | COORD_W+1 | Surface width in texels |
| cfg_height | input | COORD_W+1 | Surface height in texels |
| cfg_depth | input | COORD_W+1 | Surface depth in texels |
| cfg_pitch | input | PITCH_W | Row pitch in bytes; 0 selects an interleaved layout |
| cfg_bpp | input | BPP_W | Bytes per texel |
| in_valid | input | 1 | Coordinate valid |
| in_ready | output | 1 | Coordinate accepted when high with in_valid |
| in_x | input | COORD_W | X coordinate |
| in_y | input | COORD_W | Y coordinate |
| in_z | input | COORD_W | Z coordinate |
| out_valid | output | 1 | Offset valid |
| out_ready | input | 1 | Downstream accepts the offset |
| out_offset | output | OFF_W | Byte offset |

## Verification
The bench builds the block with its defaults: COORD_W = 8, PITCH_W = 12 and BPP_W = 3. This allows surfaces from 2x2 up to 256 texels per axis. The largest 2D square (k = 8) therefore fills every interleave bit. Small 3D shapes such as 8x4x2 and 4x4x16 show an axis dropping out of the rotation early. Tall and wide 2D shapes exercise the tile term. Pitches up to 4095 allow linear rows wider than the surface, which makes unclipped x values visible.

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int COORD_W = 8,
  parameter int PITCH_W = 12,
  parameter int BPP_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [COORD_W:0]     cfg_width,
  input  logic [COORD_W:0]     cfg_height,
  input  logic [COORD_W:0]     cfg_depth,
  input  logic [PITCH_W-1:0]   cfg_pitch,
  input  logic [BPP_W-1:0]     cfg_bpp,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [COORD_W-1:0]   in_x,
  input  logic [COORD_W-1:0]   in_y,
  input  logic [COORD_W-1:0]   in_z,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [(3*COORD_W+BPP_W > COORD_W+PITCH_W+1 ? 3*COORD_W+BPP_W : COORD_W+PITCH_W+1)-1:0] out_offset
);
  localparam int DW    = COORD_W + 1;
  localparam int LW    = $clog2(DW);
  localparam int IDX_W = 3 * COORD_W;
  localparam int IXW   = $clog2(IDX_W);
  localparam int LIN_W = COORD_W + PITCH_W + 1;
  localparam int OFF_W = (IDX_W + BPP_W > LIN_W) ? IDX_W + BPP_W : LIN_W;

  function automatic logic [LW-1:0] lg2(input logic [DW-1:0] v);
    lg2 = '0;
    for (int i = 0; i < DW; i++) if (v[i]) lg2 = LW'(i);
  endfunction

  function automatic int mn(input int a, input int b);
    mn = (a < b) ? a : b;
  endfunction

  logic             m_lin, m_3d, advance;
  logic [DW-1:0]    side;
  logic [LW-1:0]    k;
  logic [IDX_W-1:0] idx2, idx3;
  logic [OFF_W-1:0] lin, sel;
  logic             v1, lin1;
  logic [OFF_W-1:0] val1;

  assign m_lin    = |cfg_pitch;
  assign m_3d     = !m_lin && (cfg_depth > DW'(1));
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign side     = (cfg_width < cfg_height) ? cfg_width : cfg_height;
  assign k        = lg2(side);
  assign lin      = OFF_W'(in_y) * OFF_W'(cfg_pitch) + OFF_W'(in_x) * OFF_W'(cfg_bpp);

  always_comb begin
    idx2 = '0;
    for (int i = 0; i < COORD_W; i++) begin
      if (i < int'(k)) begin
        idx2[2*i]   = in_x[i];
        idx2[2*i+1] = in_y[i];
      end
    end
    idx2 = idx2 + (((IDX_W'(in_y >> k) * IDX_W'(cfg_width >> k)) + IDX_W'(in_x >> k)) << {k, 1'b0});
  end

  always_comb begin
    int lw, lh, ld;
    lw = int'(lg2(cfg_width));
    lh = int'(lg2(cfg_height));
    ld = int'(lg2(cfg_depth));
    idx3 = '0;
    for (int r = 0; r < COORD_W; r++) begin
      if (r < lw) idx3[IXW'(mn(r, lw) + mn(r, lh) + mn(r, ld))] = in_x[r];
      if (r < lh) idx3[IXW'(mn(r+1, lw) + mn(r, lh) + mn(r, ld))] = in_y[r];
      if (r < ld) idx3[IXW'(mn(r+1, lw) + mn(r+1, lh) + mn(r, ld))] = in_z[r];
    end
  end

  assign sel = m_lin ? lin : (m_3d ? OFF_W'(idx3) : OFF_W'(idx2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; lin1 <= 1'b0; val1 <= '0;
      out_valid <= 1'b0; out_offset <= '0;
    end else if (advance) begin
      v1   <= in_valid;
      lin1 <= m_lin;
      val1 <= sel;
      out_valid  <= v1;
      out_offset <= lin1 ? val1 : val1 * OFF_W'(cfg_bpp);
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && in_ready);
  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset));
  // R8
  flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v1 && out_ready |=> out_valid);
  // R7
  align4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_pitch == '0 && cfg_bpp == BPP_W'(4) |-> out_offset[1:0] == 2'b00);
  // R7
  align2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cfg_pitch == '0 && cfg_bpp == BPP_W'(2) |-> out_offset[0] == 1'b0);
endmodule

// File: tb/swz_addr_gen_tb.sv
module swz_addr_gen_tb;
  localparam int CW = 8, PW = 12, BW = 3;
  localparam int OW = 3*CW+BW;

  logic clk = 0, rst_n = 0;
  logic [CW:0] cfg_width = 16, cfg_height = 16, cfg_depth = 1;
  logic [PW-1:0] cfg_pitch = 0;
  logic [BW-1:0] cfg_bpp = 1;
  logic in_valid = 0, in_ready, out_valid, out_ready = 1;
  logic [CW-1:0] in_x = 0, in_y = 0, in_z = 0;
  logic [OW-1:0] out_offset;

  swz_addr_gen #(.COORD_W(CW), .PITCH_W(PW), .BPP_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_depth(cfg_depth), .cfg_pitch(cfg_pitch), .cfg_bpp(cfg_bpp),
    .in_valid(in_valid), .in_ready(in_ready), .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_offset(out_offset));

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit acc = 0, fr = 0, held_pend = 0, done = 0;
  longint held_val;
  longint exp_q[$];
  string tag_q[$];
  int edge_q[$];

  function automatic longint ref_lin(longint x, longint y);
    return y * cfg_pitch + x * cfg_bpp;
  endfunction

  function automatic longint ref_2d(longint x, longint y);
    longint m, w, h, side; int k;
    w = cfg_width; h = cfg_height; side = (w < h) ? w : h;
    k = 0; while ((64'd1 << (k+1)) <= side) k++;
    m = 0;
    for (int i = 0; i < k; i++) begin
      m |= ((x >> i) & 1) << (2*i);
      m |= ((y >> i) & 1) << (2*i+1);
    end
    m += (((y >> k) * (w >> k)) + (x >> k)) << (2*k);
    return m * cfg_bpp;
  endfunction

  function automatic longint ref_3d(longint x, longint y, longint z);
    longint w, h, d, v; int i, o;
    w = cfg_width >> 1; h = cfg_height >> 1; d = cfg_depth >> 1;
    v = 0; i = 0;
    do begin
      o = i;
      if (w != 0) begin v |= (x & 1) << i; i++; x >>= 1; w >>= 1; end
      if (h != 0) begin v |= (y & 1) << i; i++; y >>= 1; h >>= 1; end
      if (d != 0) begin v |= (z & 1) << i; i++; z >>= 1; d >>= 1; end
    end while (o != i);
    return v * cfg_bpp;
  endfunction

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1; tests++; fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 150000", cyc);
      summary();
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (held_pend) begin
        tests++;
        if (!out_valid || out_offset != OW'(held_val)) begin
          fails++;
          $display("FAIL R9 hold: actual valid=%0b off=%0d expected valid=1 off=%0d",
                   out_valid, out_offset, held_val);
        end
        held_pend = 0;
      end
      if (out_valid && !out_ready) begin
        tests++;
        if (in_ready) begin
          fails++;
          $display("FAIL R9 in_ready during stall: actual 1 expected 0");
        end
        held_pend = 1; held_val = longint'(out_offset);
      end
      if (out_valid && out_ready) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R8 spurious output: actual off=%0d expected none", out_offset);
        end else begin
          longint e; string t; int ed;
          e = exp_q.pop_front(); t = tag_q.pop_front(); ed = edge_q.pop_front();
          if (out_offset != OW'(e)) begin
            fails++;
            $display("FAIL %s offset: actual %0d expected %0d", t, out_offset, e);
          end
          if (fr) begin
            tests++;
            if (cyc != ed + 1) begin
              fails++;
              $display("FAIL R8 latency: actual edge %0d expected %0d", cyc, ed + 1);
            end
          end
        end
      end
      acc = in_valid && in_ready;
      if (acc) begin
        edge_q.push_back(cyc + 1);
        if (cfg_pitch != 0) begin
          exp_q.push_back(ref_lin(in_x, in_y)); tag_q.push_back("R2/R10 linear");
        end else if (cfg_depth <= 1) begin
          exp_q.push_back(ref_2d(in_x, in_y)); tag_q.push_back("R3/R4/R5/R7 2D");
        end else begin
          exp_q.push_back(ref_3d(in_x, in_y, in_z)); tag_q.push_back("R3/R6/R7 3D");
        end
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    out_ready = fr ? 1'b1 : (($urandom % 4) != 0);
  endtask

  task automatic send(input int x, input int y, input int z);
    in_x = CW'(x); in_y = CW'(y); in_z = CW'(z); in_valid = 1;
    forever begin step(); if (acc) break; end
    in_valid = 0;
    if (!fr && ($urandom % 3) == 0) step();
  endtask

  task automatic drain();
    fr = 0;
    while (exp_q.size() != 0) begin @(posedge clk); #1; out_ready = 1; end
    step(); step();
  endtask

  task automatic run_cfg(input int w, input int h, input int d, input int p,
                         input int b, input int n, input bit full, input bit oor);
    cfg_width = (CW+1)'(w); cfg_height = (CW+1)'(h); cfg_depth = (CW+1)'(d);
    cfg_pitch = PW'(p); cfg_bpp = BW'(b);
    fr = full; out_ready = 1;
    step();
    for (int i = 0; i < n; i++) begin
      int x, y, z;
      x = oor ? int'($urandom % 256) : int'($urandom % w);
      y = int'($urandom % h);
      z = (d > 1) ? int'($urandom % d) : int'($urandom % 256);
      send(x, y, z);
    end
    drain();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: idle during reset
    tests++;
    if (out_valid || !in_ready) begin
      fails++; $display("FAIL R1 in reset: actual v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end
    rst_n = 1;
    @(negedge clk);
    // R1: idle after release
    tests++;
    if (out_valid || !in_ready) begin
      fails++; $display("FAIL R1 after reset: actual v=%0b r=%0b expected v=0 r=1", out_valid, in_ready);
    end
    // R2 and R10: linear, x beyond row width, full rate for R8
    run_cfg(16, 16, 1, 600, 2, 60, 1, 1);
    run_cfg(16, 16, 1, 40, 4, 60, 0, 0);
    // R4: square 2D
    run_cfg(16, 16, 1, 0, 4, 80, 1, 0);
    run_cfg(256, 256, 1, 0, 2, 80, 0, 0);
    // R5: non-square 2D, depth 0 also selects 2D (R3)
    run_cfg(32, 8, 0, 0, 1, 80, 0, 0);
    run_cfg(8, 32, 1, 0, 2, 80, 1, 0);
    // R6: 3D with axes leaving the rotation
    run_cfg(8, 4, 2, 0, 4, 80, 0, 0);
    run_cfg(4, 4, 16, 0, 1, 80, 1, 0);
    run_cfg(2, 64, 8, 0, 2, 80, 0, 0);
    // R10: out-of-range again with stalls
    run_cfg(8, 8, 1, 300, 1, 40, 0, 1);
    done = 1;
    summary();
  end
endmodule